// File: doc/BRIEF.md
# Constant-Rate Secondary Clock Divider

This block sits beside a selectable-frequency oscillator and derives a secondary clock that stays at a fixed 4 MHz whatever setting the oscillator runs at. A two-bit setting code tells the block whether the oscillator runs at 32, 24, 16 or 4 MHz, and the block picks the integer divide ratio that brings that frequency down to 4 MHz. A gear-shift request forces the low 4 MHz setting, as used when the oscillator drops to its low frequency in a low-power mode. The secondary output is a level that a clock gate or the consuming logic can use as a clock or as a clock enable.

A change of setting never truncates or stretches an output period. The new code is registered on the next oscillator edge and is held pending until the current output period ends. The new ratio takes effect exactly at that boundary, which is also a rising edge of the output, so the output keeps its rate with no glitch and no missing pulse. A one-cycle done flag marks the first cycle under the new ratio.

Top module: `fixed_rate_clkdiv`

## Requirements
- R1: While reset is held and right after it, the block uses the base setting (code 2'b00, ratio 8): the output is high and the done flag is low, and the first period after release lasts 8 cycles.
- R2: The setting code selects the ratio: 2'b00 (32 MHz) gives 8, 2'b01 (24 MHz) gives 6, 2'b10 (16 MHz) gives 4, 2'b11 (4 MHz) gives 1.
- R3: Each output period starts high. For an even ratio N the output is high for the first N/2 cycles and low for the last N/2. For ratio 1 the output stays high on every cycle.
- R4: While the gear-shift request is high the block uses code 2'b11 (ratio 1) whatever the setting input holds, and changes of the setting input have no effect.
- R5: A code change is registered on the next rising edge and is applied only when the current period ends, so that period completes under the old ratio. With the change driven in the first cycle of a period of ratio N ≥ 2, the new ratio starts N cycles later.
- R6: The done flag is high for exactly one cycle, in the first cycle of the first period under a new ratio, and only when the ratio has actually changed.
- R7: A code change that is reverted before the current period ends leaves the ratio unchanged and produces no done pulse.
- R8: Leaving ratio 1, a code change driven in one cycle is registered at the next edge and applied at the edge after it, so the new ratio and the done flag appear two cycles after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset |
| freq_sel | input | 2 | Oscillator setting code (00=32, 01=24, 10=16, 11=4 MHz) |
| gear_req | input | 1 | Gear-shift request, forces the 4 MHz setting while high |
| clk4_out | output | 1 | Constant-rate 4 MHz secondary output |
| switch_done | output | 1 | One-cycle pulse in the first cycle under a new ratio |

## Verification
A code change is registered one edge after it is driven and applied at the first period end after that edge, and the done flag and new ratio appear in the cycle that follows; from a period start that is N cycles for ratio N ≥ 2 and 2 cycles from ratio 1. The bench drives inputs and samples outputs on falling edges and counts samples from a period start, taking each done pulse as the new sample zero, so every expected done position and high-cycle count is a fixed sample index. Each new code is applied in the done cycle, which lets the same window check that the old period ran its full length with the right duty before the switch.

// File: rtl/crdiv_pkg.sv
package crdiv_pkg;

   typedef enum logic [1:0] {
      SEL_F32 = 2'b00,
      SEL_F24 = 2'b01,
      SEL_F16 = 2'b10,
      SEL_F4  = 2'b11
   } osc_sel_e;

   localparam int NUM_SEL = 4;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/crdiv_sel_reg.sv
module crdiv_sel_reg
   import crdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] freq_sel,
   input  logic       gear_req,
   output logic [1:0] sel_q
);

   // Registered setting code; the gear shift overrides to the low setting.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_F32;
      end else if (gear_req) begin
         sel_q <= SEL_F4;
      end else begin
         sel_q <= freq_sel;
      end
   end

   // R4: a gear request always lands on the low setting code
   assert_gear_low_code_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      gear_req |=> (sel_q == SEL_F4));

endmodule

// File: rtl/crdiv_ratio_lut.sv
module crdiv_ratio_lut
   import crdiv_pkg::*;
#(
   parameter int RATIO_F32 = 8,
   parameter int RATIO_F24 = 6,
   parameter int RATIO_F16 = 4,
   parameter int RATIO_F4  = 1,
   parameter int RAT_W     = 4
) (
   input  logic [1:0]       sel_code,
   output logic [RAT_W-1:0] ratio
);

   logic [RAT_W-1:0] tbl [NUM_SEL];

   for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_tbl
      localparam int R = (gi == 0) ? RATIO_F32 :
                         (gi == 1) ? RATIO_F24 :
                         (gi == 2) ? RATIO_F16 : RATIO_F4;
      if (R < 1 || R >= (1 << RAT_W)) begin : g_bad
         $error("crdiv_ratio_lut: ratio %0d does not fit %0d bits", R, RAT_W);
      end
      assign tbl[gi] = RAT_W'(R);
   end

   assign ratio = tbl[sel_code];

endmodule

// File: rtl/crdiv_counter.sv
module crdiv_counter #(
   parameter int RAT_W       = 4,
   parameter int RESET_RATIO = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAT_W-1:0] next_ratio,
   output logic             clk_out,
   output logic             done_pulse
);

   localparam logic [RAT_W-1:0] ONE   = RAT_W'(1);
   localparam logic [RAT_W-1:0] R_RST = RAT_W'(RESET_RATIO);

   logic [RAT_W-1:0] cnt;
   logic [RAT_W-1:0] ratio_q;
   logic             wrap;
   logic             done_q;

   assign wrap = (cnt == (ratio_q - ONE));

   // The active ratio is reloaded only at the period boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= R_RST;
         done_q  <= 1'b0;
      end else if (wrap) begin
         cnt     <= '0;
         ratio_q <= next_ratio;
         done_q  <= (next_ratio != ratio_q);
      end else begin
         cnt     <= cnt + ONE;
         done_q  <= 1'b0;
      end
   end

   // High for the first half of each period; ratio 1 stays high.
   assign clk_out    = (ratio_q == ONE) || (cnt < (ratio_q >> 1));
   assign done_pulse = done_q;

   // R3: the phase counter never reaches the active ratio
   assert_cnt_in_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratio_q);

   // R3: the output only rises at the start of a period
   assert_rise_at_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> (cnt == '0));

   // R5: the ratio changes only right after a period end
   assert_ratio_at_wrap_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q != $past(ratio_q)) |-> $past(wrap));

   // R6: done marks a real ratio change
   assert_done_on_change_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (ratio_q != $past(ratio_q)));

   // R6: every ratio change is flagged
   assert_change_flagged_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q != $past(ratio_q)) |-> done_pulse);

endmodule

// File: rtl/fixed_rate_clkdiv.sv
module fixed_rate_clkdiv
   import crdiv_pkg::*;
#(
   parameter int RATIO_F32 = 8,
   parameter int RATIO_F24 = 6,
   parameter int RATIO_F16 = 4,
   parameter int RATIO_F4  = 1
) (
   input  logic       clk_osc,
   input  logic       rst_n,
   input  logic [1:0] freq_sel,
   input  logic       gear_req,
   output logic       clk4_out,
   output logic       switch_done
);

   localparam int MAX_RATIO = max_of4(RATIO_F32, RATIO_F24, RATIO_F16, RATIO_F4);
   localparam int RAT_W     = $clog2(MAX_RATIO + 1);

   for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_chk
      localparam int R = (gi == 0) ? RATIO_F32 :
                         (gi == 1) ? RATIO_F24 :
                         (gi == 2) ? RATIO_F16 : RATIO_F4;
      if (R != 1 && (R % 2) != 0) begin : g_odd
         $error("fixed_rate_clkdiv: ratio %0d must be 1 or even", R);
      end
   end

   logic [1:0]       sel_q;
   logic [RAT_W-1:0] next_ratio;

   crdiv_sel_reg u_sel (
      .clk      (clk_osc),
      .rst_n    (rst_n),
      .freq_sel (freq_sel),
      .gear_req (gear_req),
      .sel_q    (sel_q)
   );

   crdiv_ratio_lut #(
      .RATIO_F32 (RATIO_F32),
      .RATIO_F24 (RATIO_F24),
      .RATIO_F16 (RATIO_F16),
      .RATIO_F4  (RATIO_F4),
      .RAT_W     (RAT_W)
   ) u_lut (
      .sel_code (sel_q),
      .ratio    (next_ratio)
   );

   crdiv_counter #(
      .RAT_W       (RAT_W),
      .RESET_RATIO (RATIO_F32)
   ) u_cnt (
      .clk        (clk_osc),
      .rst_n      (rst_n),
      .next_ratio (next_ratio),
      .clk_out    (clk4_out),
      .done_pulse (switch_done)
   );

endmodule

// File: tb/fixed_rate_clkdiv_test.sv
`timescale 1ns/1ps
module fixed_rate_clkdiv_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] freq_sel = 2'b00;
   logic       gear_req = 1'b0;
   logic       clk4_out;
   logic       switch_done;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   fixed_rate_clkdiv uut (
      .clk_osc     (clk),
      .rst_n       (rst_n),
      .freq_sel    (freq_sel),
      .gear_req    (gear_req),
      .clk4_out    (clk4_out),
      .switch_done (switch_done)
   );

   typedef struct packed {
      logic [1:0] sel;
      logic       gear;
      int         cur;      // ratio in force when the vector is applied
      int         exp_done; // sample index of the done pulse
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      '{2'b01, 1'b0, 8, 8},  // R2 R5: 8 -> 6
      '{2'b10, 1'b0, 6, 6},  // R2: 6 -> 4
      '{2'b11, 1'b0, 4, 4},  // R2: 4 -> 1
      '{2'b00, 1'b0, 1, 2},  // R8: 1 -> 8
      '{2'b00, 1'b1, 8, 8},  // R4: gear down 8 -> 1
      '{2'b01, 1'b0, 1, 2},  // R8: 1 -> 6
      '{2'b11, 1'b0, 6, 6},  // 6 -> 1
      '{2'b10, 1'b0, 1, 2},  // R8: 1 -> 4
      '{2'b00, 1'b0, 4, 4},  // 4 -> 8
      '{2'b10, 1'b1, 8, 8}   // R4: gear wins over select
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int s;
      int hi;
      int dn;
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk(clk4_out == 1'b1, "R1 out in reset", clk4_out, 1);
         chk(switch_done == 1'b0, "R1 done in reset", switch_done, 0);
      end
      rst_n = 1'b1;  // this falling edge is sample 0 of the first period

      // Vector walk: each vector applied in sample 0 of a period.
      for (int i = 0; i < NVEC; i++) begin
         freq_sel = VECS[i].sel;
         gear_req = VECS[i].gear;
         s  = 0;
         hi = clk4_out ? 1 : 0;
         chk(clk4_out == 1'b1, "R3 period starts high", clk4_out, 1);
         while (s < 40) begin
            @(negedge clk);
            s++;
            if (switch_done) break;
            if (s < VECS[i].cur && clk4_out) hi++;
         end
         chk(s == VECS[i].exp_done, "R5 R6 done position", s, VECS[i].exp_done);
         chk(hi == ((VECS[i].cur == 1) ? 1 : VECS[i].cur / 2), "R3 high cycles",
             hi, (VECS[i].cur == 1) ? 1 : VECS[i].cur / 2);
      end

      // R4: with gear held, select changes are ignored (ratio stays 1).
      freq_sel = 2'b01;
      hi = 0;
      dn = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (clk4_out) hi++;
         if (switch_done) dn++;
      end
      chk(dn == 0, "R4 no done while gear held", dn, 0);
      chk(hi == 12, "R4 output stays at ratio 1", hi, 12);

      // Back to base setting: from ratio 1 done at sample 2 (R8).
      gear_req = 1'b0;
      freq_sel = 2'b00;
      s = 0;
      while (s < 40) begin
         @(negedge clk);
         s++;
         if (switch_done) break;
      end
      chk(s == 2, "R8 leave ratio 1", s, 2);

      // R7: change reverted before the boundary has no effect.
      freq_sel = 2'b01;
      @(negedge clk);
      freq_sel = 2'b00;
      hi = 0;
      dn = 0;
      for (int k = 1; k <= 20; k++) begin
         if (k > 1) @(negedge clk);
         if (switch_done) dn++;
         if (k < 16 && clk4_out) hi++;
         if (k == 7)  chk(clk4_out == 1'b0, "R7 end of period low", clk4_out, 0);
         if (k == 8)  chk(clk4_out == 1'b1, "R7 period still 8", clk4_out, 1);
         if (k == 16) chk(clk4_out == 1'b1, "R7 second period 8", clk4_out, 1);
      end
      chk(dn == 0, "R7 no done after revert", dn, 0);
      chk(hi == 7, "R7 high cycles over samples 1..15", hi, 7);

      // R1: reset mid-run from ratio 1 returns to the base ratio.
      freq_sel = 2'b11;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      freq_sel = 2'b00;
      @(negedge clk);
      chk(clk4_out == 1'b1, "R1 out in mid-run reset", clk4_out, 1);
      chk(switch_done == 1'b0, "R1 done in mid-run reset", switch_done, 0);
      rst_n = 1'b1;
      hi = clk4_out ? 1 : 0;
      dn = 0;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (switch_done) dn++;
         if (k < 8 && clk4_out) hi++;
         if (k == 8) chk(clk4_out == 1'b1, "R1 first period 8 cycles", clk4_out, 1);
      end
      chk(hi == 4, "R1 R3 base duty", hi, 4);
      chk(dn == 0, "R6 no done without change", dn, 0);

      summary();
      $finish;
   end

endmodule